// File: doc/BRIEF.md
# Debounced GPI Interrupt Port

This block watches a bank of fifteen general-purpose input pins. Each pin passes through its own debouncer. The hold time is set by a 5-bit field and counted in 1 ms timebase ticks. The debounced levels of the input pins are kept in a port-value register that the host can read.

Per-pin mask and trigger bits decide which debounced edges raise a single interrupt request. That request goes to a shared interrupt combiner. It stays high until the host reads the port-value register. Level changes that settle while a host bus read is in progress are held back until the read ends, and an enabled edge among them raises the request again.

Each pin debouncer is a four-state machine:
- `DB_OUT`: the pin is driven as an output.
- `DB_SETTLE`: the blind period after the pin returns to input.
- `DB_IDLE`: the pin is stable and armed.
- `DB_CHANGE`: a new level is being timed.

The transitions are:
- Any state goes to `DB_OUT` when the direction bit is 1.
- `DB_OUT` goes to `DB_SETTLE` when the direction bit is 0.
- `DB_SETTLE` goes to `DB_IDLE` after a full hold time has been counted.
- `DB_IDLE` goes to `DB_CHANGE` when the raw input differs from the debounced level.
- `DB_CHANGE` goes back to `DB_IDLE` in one of two ways: a restart, when the raw input returns to the debounced level, or an accept, when the hold time expires and the new level is taken.

The interrupt controller is a three-state machine:
- `IRQ_IDLE`: no request.
- `IRQ_PEND`: the request is high.
- `IRQ_DRAIN`: the request was cleared by a read while the bus read is still active.

The transitions are:
- raise: `IRQ_IDLE` to `IRQ_PEND`.
- clear: `IRQ_PEND` to `IRQ_IDLE`, or to `IRQ_DRAIN` when the bus is busy.
- disable: `IRQ_PEND` to `IRQ_IDLE`.
- release: `IRQ_DRAIN` to `IRQ_IDLE`.
- re-raise: `IRQ_DRAIN` to `IRQ_PEND`.

Top module: `gpi_irq_port`

## Requirements
- R1: With debounce setting n (0 to 31), a raw level change is accepted after it has been held for 9 + n consecutive 1 ms ticks, and not earlier.
- R2: When the raw input returns to the debounced level before the hold time has expired, the change is discarded and its count restarts from zero.
- R3: After a pin switches from output to input, no transition on that pin can raise an interrupt for one full hold time. During that period its debounced level follows the raw input.
- R4: `rd_data` shows the debounced level of every input pin whatever the mask bits are, and shows 0 for pins whose `pin_dir_out` bit is 1.
- R5: A mask bit of 0 lets its pin raise the interrupt. A mask bit of 1 blocks it.
- R6: A trigger bit of 0 selects rising edges only. A trigger bit of 1 selects both rising and falling edges.
- R7: `irq` stays high until a read strobe (`rd_value`). Enabled edges that arrive while `irq` is high update `rd_data` but do not change `irq`.
- R8: While `host_rd_busy` is 1, the port-value register is frozen. Changes that settle during that time are taken in once it drops, and an enabled edge among them raises `irq` again.
- R9: A pin whose `pin_dir_out` bit is 1 never raises the interrupt.
- R10: While the global enable bit is 0, `irq` stays low and no interrupt is generated.
- R11: At reset all pins are inputs, all mask bits are 1, all trigger bits are 0, the debounce setting is 0, the global enable is 0, and `irq` and `rd_data` are 0.
- R12: Registers are written with `wr_en`, selected by `wr_addr`:
  - 0: mask (bit i is pin i)
  - 1: trigger (bit i is pin i)
  - 2: debounce setting (bits 4:0)
  - 3: global enable (bit 0)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | 15 | Raw pin levels |
| pin_dir_out | input | 15 | 1 = pin is an output |
| tick_ms | input | 1 | One-cycle pulse every 1 ms |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 15 | Write data |
| host_rd_busy | input | 1 | A host bus read is in progress |
| rd_value | input | 1 | Read strobe for the port-value register |
| rd_data | output | 15 | Port-value register (input pins only) |
| irq | output | 1 | Pending interrupt request |

## Verification
The assertions assume the following about the inputs:
- `tick_ms` is a single-cycle pulse, well spaced relative to the clock.
- `rd_value` is asserted only inside a window in which `host_rd_busy` is high.
- The debounce setting is not rewritten while a change is being timed.

The stimulus respects all three. It produces one tick every four clocks. It wraps every read strobe in a busy window that starts with the strobe and lasts at least two cycles. It writes the debounce setting only while every pin is stable.

// File: rtl/gpi_pkg.sv
package gpi_pkg;

    typedef enum logic [1:0] {
        DB_OUT    = 2'd0,
        DB_SETTLE = 2'd1,
        DB_IDLE   = 2'd2,
        DB_CHANGE = 2'd3
    } db_state_e;

    typedef enum logic [1:0] {
        IRQ_IDLE  = 2'd0,
        IRQ_PEND  = 2'd1,
        IRQ_DRAIN = 2'd2
    } irq_state_e;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_TRIG = 2'd1,
        SEL_DEB  = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpi_cfg_regs.sv
module gpi_cfg_regs
    import gpi_pkg::*;
#(
    parameter int NPINS = 15,
    parameter int DBW   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] mask_o,
    output logic [NPINS-1:0] trig_o,
    output logic [DBW-1:0]   deb_o,
    output logic             en_o
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(wr_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '1;
            trig_o <= '0;
            deb_o  <= '0;
            en_o   <= 1'b0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_MASK: mask_o <= wr_data;
                SEL_TRIG: trig_o <= wr_data;
                SEL_DEB:  deb_o  <= wr_data[DBW-1:0];
                SEL_CTRL: en_o   <= wr_data[0];
                default:  en_o   <= en_o;
            endcase
        end
    end

    AST_RESET_MASKED: assert property (@(posedge clk)
        $rose(rst_n) |-> (&mask_o && !en_o)) else $error("reset config"); // R11

endmodule

// File: rtl/gpi_debounce.sv
module gpi_debounce
    import gpi_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_i,
    input  logic          dir_out_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          stable_o,
    output logic          armed_o
);

    db_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          stab_q, stab_d;
    logic          last_tick;

    assign last_tick = (cnt_q + CW'(1)) >= limit_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= DB_SETTLE;
            cnt_q  <= '0;
            stab_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            stab_q <= stab_d;
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        stab_d = stab_q;
        if (dir_out_i) begin
            st_d   = DB_OUT;
            cnt_d  = '0;
            stab_d = raw_i;
        end else begin
            unique case (st_q)
                DB_OUT: begin
                    st_d   = DB_SETTLE;
                    cnt_d  = '0;
                    stab_d = raw_i;
                end
                DB_SETTLE: begin
                    stab_d = raw_i;
                    if (tick_i) begin
                        if (last_tick) begin
                            st_d  = DB_IDLE;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                DB_IDLE: begin
                    if (raw_i != stab_q) begin
                        st_d  = DB_CHANGE;
                        cnt_d = '0;
                    end
                end
                DB_CHANGE: begin
                    if (raw_i == stab_q) begin
                        st_d  = DB_IDLE;       // restart
                        cnt_d = '0;
                    end else if (tick_i) begin
                        if (last_tick) begin
                            st_d   = DB_IDLE;  // accept
                            cnt_d  = '0;
                            stab_d = raw_i;
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                default: st_d = DB_SETTLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        stable_o = stab_q;
        armed_o  = (st_q == DB_IDLE) || (st_q == DB_CHANGE);
    end

    AST_OUT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        dir_out_i |=> (st_q == DB_OUT && stab_q == $past(raw_i))) else $error("out track"); // R9
    AST_SETTLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DB_SETTLE && !dir_out_i) |=> (stab_q == $past(raw_i) && st_q != DB_CHANGE)) else $error("settle"); // R3
    AST_ACCEPT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && !tick_i && !dir_out_i) |=> $stable(stab_q)) else $error("no tick accept"); // R1

endmodule

// File: rtl/gpi_irq_ctrl.sv
module gpi_irq_ctrl
    import gpi_pkg::*;
#(
    parameter int NPINS = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] stable_i,
    input  logic [NPINS-1:0] armed_i,
    input  logic [NPINS-1:0] dir_out_i,
    input  logic [NPINS-1:0] mask_i,
    input  logic [NPINS-1:0] trig_i,
    input  logic             en_i,
    input  logic             busy_i,
    input  logic             rd_i,
    output logic [NPINS-1:0] value_o,
    output logic             irq_o
);

    irq_state_e       st_q, st_d;
    logic [NPINS-1:0] value_q;
    logic [NPINS-1:0] rise, fall, hit_vec;
    logic             hit;

    always_comb begin
        rise    = stable_i & ~value_q;
        fall    = ~stable_i & value_q;
        hit_vec = armed_i & ~dir_out_i & ~mask_i & (rise | (trig_i & fall));
        hit     = en_i && !busy_i && (|hit_vec);
    end

    // state and value registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= IRQ_IDLE;
            value_q <= '0;
        end else begin
            st_q <= st_d;
            if (!busy_i) value_q <= stable_i;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_IDLE: if (hit) st_d = IRQ_PEND;                 // raise
            IRQ_PEND: begin
                if (!en_i)      st_d = IRQ_IDLE;                // disable
                else if (rd_i)  st_d = hit    ? IRQ_PEND  :
                                       busy_i ? IRQ_DRAIN : IRQ_IDLE; // clear
            end
            IRQ_DRAIN: if (!busy_i) st_d = hit ? IRQ_PEND : IRQ_IDLE; // re-raise / release
            default: st_d = IRQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_o   = (st_q == IRQ_PEND) && en_i;
        value_o = value_q & ~dir_out_i;
    end

    AST_VALUE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(value_q)) else $error("frozen"); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !rd_i) |=> (st_q == IRQ_PEND)) else $error("sticky"); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && busy_i) |=> !irq_o) else $error("read clear"); // R7
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && st_q != IRQ_DRAIN) |=> (st_q == IRQ_IDLE)) else $error("disabled"); // R10

endmodule

// File: rtl/gpi_irq_port.sv
module gpi_irq_port
    import gpi_pkg::*;
#(
    parameter int NPINS   = 15,
    parameter int DBW     = 5,
    parameter int BASE_MS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_raw,
    input  logic [NPINS-1:0] pin_dir_out,
    input  logic             tick_ms,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [NPINS-1:0] wr_data,
    input  logic             host_rd_busy,
    input  logic             rd_value,
    output logic [NPINS-1:0] rd_data,
    output logic             irq
);

    localparam int CW = $clog2(BASE_MS + (1 << DBW) + 1);

    logic [NPINS-1:0] mask, trig, stable, armed;
    logic [DBW-1:0]   deb;
    logic             en;
    logic [CW-1:0]    limit;

    assign limit = CW'(BASE_MS) + CW'(deb);

    gpi_cfg_regs #(.NPINS(NPINS), .DBW(DBW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mask_o  (mask),
        .trig_o  (trig),
        .deb_o   (deb),
        .en_o    (en)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpi_debounce #(.CW(CW)) u_deb (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_i     (pin_raw[i]),
            .dir_out_i (pin_dir_out[i]),
            .tick_i    (tick_ms),
            .limit_i   (limit),
            .stable_o  (stable[i]),
            .armed_o   (armed[i])
        );
    end

    gpi_irq_ctrl #(.NPINS(NPINS)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .stable_i  (stable),
        .armed_i   (armed),
        .dir_out_i (pin_dir_out),
        .mask_i    (mask),
        .trig_i    (trig),
        .en_i      (en),
        .busy_i    (host_rd_busy),
        .rd_i      (rd_value),
        .value_o   (rd_data),
        .irq_o     (irq)
    );

    AST_OUTPUT_PIN_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & pin_dir_out) == '0) else $error("out pin value"); // R4

endmodule

// File: tb/gpi_irq_port_tb.sv
module gpi_irq_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 15;
    localparam int MS = 4;            // clocks per ms tick

    logic         clk = 0;
    logic         rst_n = 0;
    logic [N-1:0] pin_raw = '0;
    logic [N-1:0] pin_dir_out = '0;
    logic         tick_ms = 0;
    logic         wr_en = 0;
    logic [1:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic         host_rd_busy = 0;
    logic         rd_value = 0;
    logic [N-1:0] rd_data;
    logic         irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int divc = 0;

    gpi_irq_port u_dut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .pin_dir_out(pin_dir_out),
        .tick_ms(tick_ms), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .host_rd_busy(host_rd_busy), .rd_value(rd_value), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        divc    <= (divc == MS-1) ? 0 : divc + 1;
        tick_ms <= (divc == MS-1);
    end

    // vector: {pin[3:0], unmask, trig, rise, exp_irq}
    localparam bit [7:0] VEC [7] = '{
        {4'd0,  1'b1, 1'b0, 1'b1, 1'b1},   // R6 rise, rising-only
        {4'd1,  1'b1, 1'b0, 1'b0, 1'b0},   // R6 fall, rising-only
        {4'd2,  1'b1, 1'b1, 1'b0, 1'b1},   // R6 fall, both edges
        {4'd3,  1'b1, 1'b1, 1'b1, 1'b1},   // R6 rise, both edges
        {4'd4,  1'b0, 1'b1, 1'b1, 1'b0},   // R5 masked rise
        {4'd14, 1'b1, 1'b0, 1'b1, 1'b1},   // R5 top pin unmasked
        {4'd5,  1'b0, 1'b0, 1'b0, 1'b0}    // R5 masked fall
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_ms(input int n);
        repeat (n*MS) @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic do_read();
        @(negedge clk);
        host_rd_busy = 1; rd_value = 1;
        @(negedge clk);
        rd_value = 0;
        @(negedge clk);
        host_rd_busy = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [N-1:0] only(input int p);
        return ~(N'(1) << p);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 irq after reset", irq, 0);
        chk("R11 rd_data after reset", rd_data, 0);

        // R11: default mask blocks; R12 enable at addr 3
        wreg(2'd3, N'(1));
        pin_raw[13] = 1;
        wait_ms(14);
        chk("R11 default mask blocks irq", irq, 0);
        chk("R4 masked level readable", rd_data[13], 1);
        pin_raw[13] = 0;
        wait_ms(14);

        // table walk
        foreach (VEC[k]) begin
            int p;
            p = int'(VEC[k][7:4]);
            wreg(2'd0, '1);
            pin_raw[p] = ~VEC[k][1];
            wait_ms(14);
            do_read();
            wreg(2'd1, VEC[k][2] ? ~only(p) : '0);
            wreg(2'd0, VEC[k][3] ? only(p) : '1);
            pin_raw[p] = VEC[k][1];
            wait_ms(14);
            chk($sformatf("R6/R5 vec%0d irq", k), irq, int'(VEC[k][0]));
            chk($sformatf("R4 vec%0d value", k), rd_data[p], int'(VEC[k][1]));
            do_read();
            chk($sformatf("R7 vec%0d cleared", k), irq, 0);
        end

        // R1: setting 3 -> 12 ms hold, rising only on pin 13
        wreg(2'd2, N'(3));
        wreg(2'd1, '0);
        wreg(2'd0, only(13));
        pin_raw[13] = 1;
        wait_ms(10);
        chk("R1 not accepted early (irq)", irq, 0);
        chk("R1 not accepted early (value)", rd_data[13], 0);
        wait_ms(4);
        chk("R1 accepted after hold", irq, 1);
        do_read();

        // R2: bounce on pin 12 restarts count
        wreg(2'd0, only(12));
        pin_raw[12] = 1;
        wait_ms(5);
        pin_raw[12] = 0;
        wait_ms(3);
        pin_raw[12] = 1;
        wait_ms(10);
        chk("R2 restart: not yet accepted", irq, 0);
        wait_ms(4);
        chk("R2 accepted after full hold", irq, 1);
        do_read();
        wreg(2'd2, N'(0));

        // R9: output pin 7 never interrupts, reads 0
        wreg(2'd1, '1);
        wreg(2'd0, only(7));
        pin_dir_out[7] = 1;
        pin_raw[7] = 1;
        wait_ms(12);
        chk("R9 output pin no irq", irq, 0);
        chk("R4 output pin reads 0", rd_data[7], 0);

        // R3: output -> input blind period on pin 6, both edges
        wreg(2'd0, only(6));
        pin_dir_out[6] = 1;
        pin_raw[6] = 1;
        wait_ms(3);
        pin_dir_out[6] = 0;
        wait_ms(2);
        pin_raw[6] = 0;
        wait_ms(3);
        chk("R3 no irq inside blind period", irq, 0);
        chk("R3 level follows raw", rd_data[6], 0);
        wait_ms(8);
        chk("R3 no irq after blind period", irq, 0);
        pin_raw[6] = 1;
        wait_ms(12);
        chk("R3 armed after blind period", irq, 1);
        do_read();

        // R7: edge while asserted only updates value
        wreg(2'd1, '0);
        wreg(2'd0, only(8) & only(9));
        pin_raw[8] = 1;
        wait_ms(12);
        chk("R7 first edge raises", irq, 1);
        pin_raw[9] = 1;
        wait_ms(12);
        chk("R7 still high", irq, 1);
        chk("R7 second value updated", rd_data[9], 1);
        do_read();
        chk("R7 cleared by read", irq, 0);

        // R8: busy freezes value and defers irq
        wreg(2'd0, only(10) & only(11));
        @(negedge clk);
        host_rd_busy = 1;
        pin_raw[10] = 1;
        wait_ms(12);
        chk("R8 irq held back while busy", irq, 0);
        chk("R8 value frozen while busy", rd_data[10], 0);
        host_rd_busy = 0;
        @(negedge clk); @(negedge clk);
        chk("R8 irq after busy", irq, 1);
        chk("R8 value after busy", rd_data[10], 1);
        // clear inside a long busy window; new edge re-raises after it
        @(negedge clk);
        host_rd_busy = 1; rd_value = 1;
        @(negedge clk);
        rd_value = 0;
        pin_raw[11] = 1;
        chk("R8 cleared during read", irq, 0);
        wait_ms(12);
        chk("R8 no irq during read", irq, 0);
        host_rd_busy = 0;
        @(negedge clk); @(negedge clk);
        chk("R8 re-raised after read", irq, 1);
        do_read();

        // R10: global enable off
        wreg(2'd3, '0);
        wreg(2'd1, '1);
        wreg(2'd0, only(0));
        pin_raw[0] = 0;
        wait_ms(12);
        chk("R10 no irq when disabled", irq, 0);
        chk("R10 value still tracks", rd_data[0], 0);
        wreg(2'd3, N'(1));
        @(negedge clk);
        chk("R10 no late irq after enable", irq, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule